// File: doc/BRIEF.md
# I2C EEPROM Slave Transaction Controller

This block is the transaction layer of a 256-byte non-volatile memory that sits behind one I2C slave address. A bit-level front end handles the wires. It hands this block decoded events: a start (or repeated start), a stop, a received byte, the master's acknowledge bit after a byte it read, and a request for the next byte to transmit. For each received byte the block answers with an acknowledge decision. For each transmit request it returns a data byte.

A write transfer carries the slave address, then a word address that loads the internal address counter, then data bytes. The data bytes collect in a four-byte page buffer, and only the two low counter bits advance between them. A stop that follows at least one data byte starts a self-timed write cycle of `WR_CYCLES` clocks. At the end of that cycle, the written page positions are copied into a register-array model of the memory. While the cycle runs, the block refuses its slave address. A write-control input set to 1 at the stop throws the buffered data away.

A read transfer returns the byte at the counter and then increments the counter. It can follow a write transfer that only set the word address, which makes a random read. Without that, it is a current-address read. Each master ACK leads to one more byte, and the 8-bit counter wraps from 255 to 0. A master NACK ends the read.

Top module: `eeprom_txn_ctrl`

## Requirements
- R1: The slave address byte is acknowledged only when it equals {DEV_ID[3:0], sel[2:0], rw} and no write cycle is running. Bit 0 is rw, where 1 means read. Any other value is NACKed, and every later byte up to the next start gets a NACK.
- R2: In a write transfer, the first byte after the address loads the address counter, and every following byte is acknowledged as data. After a stop and the write cycle, a single data byte appears at the word address.
- R3: Each data byte is stored at the page position given by counter bits [1:0], and only those two bits then increment. A fifth data byte overwrites the first position, and bits [7:2] never change.
- R4: A stop after one or more data bytes, with wc low, starts a write cycle of WR_CYCLES clocks. At its end only the page positions that were written are updated, and all other bytes keep their values.
- R5: When wc is 1 at the stop, no write cycle starts and the memory stays unchanged. The slave address is then acknowledged immediately.
- R6: While the write cycle runs, an address byte that matches is NACKed.
- R7: After a write, the counter holds the last written address plus one, within the page. A read that has no word address before it returns the byte at the counter. After reset the counter is 0.
- R8: A write transfer that carries only the word address, followed by a repeated start and a read address, returns the byte stored at that word address.
- R9: Each transmit request in a read returns mem[counter] and then increments the counter modulo 256, so 255 is followed by 0.
- R10: A master NACK ends the read, and later transmit requests produce no byte.
- R11: A start during a write abandons the buffered data, so those bytes are never committed.
- R12: After reset, ack_vld and tx_vld are 0 and all memory bytes read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Hardware address select bits |
| wc | input | 1 | Write control, 1 blocks writes |
| ev_start | input | 1 | Start or repeated start pulse |
| ev_stop | input | 1 | Stop pulse |
| ev_byte | input | 1 | Received-byte pulse |
| rx_byte | input | 8 | Received byte, valid with ev_byte |
| ev_txreq | input | 1 | Request for the next byte to send |
| mst_ack_ev | input | 1 | Master acknowledge bit is valid |
| mst_ack | input | 1 | 1 = master ACK, 0 = master NACK |
| ack_vld | output | 1 | Acknowledge decision valid, one cycle after ev_byte |
| ack_o | output | 1 | 1 = acknowledge the received byte |
| tx_vld | output | 1 | Transmit byte valid, one cycle after ev_txreq |
| tx_byte | output | 8 | Byte to transmit |

## Verification
A wrong address counter shows up on the very next read: the byte returned one cycle after the transmit request comes from the wrong location. A broken page buffer or broken commit logic only shows after the write cycle ends, so those checks read the memory back once the busy window is over, including neighbours that must not change. A write cycle that is wrongly active or wrongly idle shows up within one cycle, as the acknowledge decision on the next matching address byte.

// File: rtl/eeprom_txn_ctrl.sv
module eeprom_txn_ctrl #(
  parameter logic [3:0] DEV_ID    = 4'b1010,
  parameter int         AW        = 8,
  parameter int         DW        = 8,
  parameter int         PW        = 2,
  parameter int         WR_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sel,
  input  logic          wc,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_byte,
  input  logic [DW-1:0] rx_byte,
  input  logic          ev_txreq,
  input  logic          mst_ack_ev,
  input  logic          mst_ack,
  output logic          ack_vld,
  output logic          ack_o,
  output logic          tx_vld,
  output logic [DW-1:0] tx_byte
);
  localparam int DEPTH = 1 << AW;
  localparam int PSIZE = 1 << PW;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WADDR, S_WDATA, S_RD, S_SKIP} st_t;

  st_t              st;
  logic [AW-1:0]    cnt;
  logic [AW-PW-1:0] pg;
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    pbuf [PSIZE];
  logic [PSIZE-1:0] pmask;
  logic [TW-1:0]    timer;

  wire busy   = timer != '0;
  wire hit    = rx_byte[7:1] == {DEV_ID, sel};
  wire [PW-1:0] pos = cnt[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      pg      <= '0;
      pmask   <= '0;
      timer   <= '0;
      ack_vld <= 1'b0;
      ack_o   <= 1'b0;
      tx_vld  <= 1'b0;
      tx_byte <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PSIZE; i++) pbuf[i] <= '0;
    end else begin
      ack_vld <= ev_byte;
      tx_vld  <= 1'b0;
      if (ev_byte) ack_o <= 1'b0;

      if (busy) begin
        timer <= timer - 1'b1;
        if (timer == TW'(1)) begin
          for (int i = 0; i < PSIZE; i++)
            if (pmask[i]) mem[{pg, PW'(i)}] <= pbuf[i];
          pmask <= '0;
        end
      end

      if (ev_start) begin
        st <= S_ADDR;
        if (!busy) pmask <= '0;
      end else if (ev_stop) begin
        st <= S_IDLE;
        if (!busy) begin
          if (pmask != '0 && !wc) begin
            timer <= TW'(WR_CYCLES);
            pg    <= cnt[AW-1:PW];
          end else begin
            pmask <= '0;
          end
        end
      end else if (ev_byte) begin
        case (st)
          S_ADDR: begin
            if (hit && !busy) begin
              ack_o <= 1'b1;
              st    <= rx_byte[0] ? S_RD : S_WADDR;
            end else begin
              st <= S_SKIP;
            end
          end
          S_WADDR: begin
            ack_o <= 1'b1;
            cnt   <= rx_byte;
            st    <= S_WDATA;
          end
          S_WDATA: begin
            ack_o      <= 1'b1;
            pbuf[pos]  <= rx_byte;
            pmask[pos] <= 1'b1;
            cnt[PW-1:0] <= pos + 1'b1;
          end
          default: ;
        endcase
      end else if (ev_txreq && st == S_RD) begin
        tx_vld  <= 1'b1;
        tx_byte <= mem[cnt];
        cnt     <= cnt + 1'b1;
      end else if (mst_ack_ev && !mst_ack && st == S_RD) begin
        st <= S_IDLE;
      end
    end
  end

  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_byte && !ev_start && !ev_stop && st == S_ADDR) |=> (ack_vld && !ack_o));

  // R5
  wc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop && !wc));

  // R10
  tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> $past(ev_txreq));

  // R3
  page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATA && ev_byte && !ev_start && !ev_stop) |=> cnt[AW-1:PW] == $past(cnt[AW-1:PW]));

  // R4
  commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pmask != '0));
endmodule

// File: tb/eeprom_txn_ctrl_bench.sv
module eeprom_txn_ctrl_bench;
  localparam int WR = 16;
  localparam logic [7:0] AW_W = 8'hAA;
  localparam logic [7:0] AW_R = 8'hAB;

  logic clk = 0, rst_n = 0, wc = 0;
  logic [2:0] sel = 3'b101;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_txreq = 0, mst_ack_ev = 0, mst_ack = 0;
  logic [7:0] rx_byte = 0;
  logic ack_vld, ack_o, tx_vld;
  logic [7:0] tx_byte;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eeprom_txn_ctrl #(.WR_CYCLES(WR)) u_eeprom_txn_ctrl (
    .clk, .rst_n, .sel, .wc, .ev_start, .ev_stop, .ev_byte, .rx_byte,
    .ev_txreq, .mst_ack_ev, .mst_ack, .ack_vld, .ack_o, .tx_vld, .tx_byte);

  localparam logic [15:0] VEC [6] = '{16'h003C, 16'hFF5E, 16'h37C1, 16'h9A05, 16'hC4FF, 16'h5B80};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(); @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0; endtask
  task automatic pulse_stop();  @(negedge clk); ev_stop = 1;  @(negedge clk); ev_stop = 0;  endtask

  task automatic send(input logic [7:0] b, input bit exp, input string tag);
    @(negedge clk); ev_byte = 1; rx_byte = b;
    @(negedge clk); ev_byte = 0;
    chk(ack_vld && ack_o == exp, tag, {ack_vld, ack_o}, {1'b1, exp});
  endtask

  task automatic recv(input logic [7:0] exp, input string tag);
    @(negedge clk); ev_txreq = 1;
    @(negedge clk); ev_txreq = 0;
    chk(tx_vld && tx_byte == exp, tag, {tx_vld, tx_byte}, {1'b1, exp});
  endtask

  task automatic mack(input bit a);
    @(negedge clk); mst_ack_ev = 1; mst_ack = a;
    @(negedge clk); mst_ack_ev = 0;
  endtask

  task automatic settle(); repeat (WR + 4) @(negedge clk); endtask

  task automatic rand_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    pulse_start(); send(AW_W, 1, tag); send(a, 1, tag);
    pulse_start(); send(AW_R, 1, tag); recv(exp, tag);
    mack(0); pulse_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!ack_vld && !tx_vld, "R12 reset outputs", {ack_vld, tx_vld}, 0);
    pulse_start(); send(AW_R, 1, "R7 current read after reset");
    recv(8'h00, "R12 memory zero / R7 counter zero");
    mack(0); pulse_stop();

    for (int i = 0; i < 6; i++) begin
      pulse_start(); send(AW_W, 1, "R2 addr"); send(VEC[i][15:8], 1, "R2 word");
      send(VEC[i][7:0], 1, "R2 data"); pulse_stop(); settle();
      rand_read(VEC[i][15:8], VEC[i][7:0], "R8 random read back");
    end

    pulse_start(); send(8'hA0, 0, "R1 wrong address nack");
    send(8'h12, 0, "R1 later bytes nacked"); pulse_stop();
    pulse_start(); send(AW_W & 8'hFD, 0, "R1 sel mismatch"); pulse_stop();

    pulse_start(); send(AW_W, 1, "R3 addr"); send(8'h42, 1, "R3 word");
    for (int i = 1; i <= 5; i++) send(8'(i), 1, "R3 page data");
    pulse_stop();
    pulse_start(); send(AW_W, 0, "R6 nack while busy"); pulse_stop();
    settle();
    pulse_start(); send(AW_R, 1, "R7 addr");
    recv(8'h02, "R7 counter after page write 0x43");
    mack(0); pulse_stop();
    pulse_start(); send(AW_W, 1, "R3 addr"); send(8'h40, 1, "R3 word");
    pulse_start(); send(AW_R, 1, "R3 addr");
    recv(8'h03, "R3 wrap 0x40"); mack(1); recv(8'h04, "R3 wrap 0x41"); mack(1);
    recv(8'h05, "R3 overwrite 0x42"); mack(1); recv(8'h02, "R3 0x43"); mack(0); pulse_stop();

    pulse_start(); send(AW_W, 1, "R4 addr"); send(8'h61, 1, "R4 word");
    send(8'hAA, 1, "R4 d0"); send(8'hBB, 1, "R4 d1"); pulse_stop(); settle();
    pulse_start(); send(AW_W, 1, "R4 addr"); send(8'h60, 1, "R4 word");
    pulse_start(); send(AW_R, 1, "R4 addr");
    recv(8'h00, "R4 0x60 untouched"); mack(1); recv(8'hAA, "R4 0x61"); mack(1);
    recv(8'hBB, "R4 0x62"); mack(1); recv(8'h00, "R4 0x63 untouched"); mack(0); pulse_stop();

    wc = 1;
    pulse_start(); send(AW_W, 1, "R5 addr"); send(8'h10, 1, "R5 word");
    send(8'h77, 1, "R5 data"); pulse_stop();
    pulse_start(); send(AW_W, 1, "R5 no cycle, ack at once"); pulse_stop();
    wc = 0; settle();
    rand_read(8'h10, 8'h00, "R5 memory unchanged");

    pulse_start(); send(AW_W, 1, "R9 addr"); send(8'hFF, 1, "R9 word");
    pulse_start(); send(AW_R, 1, "R9 addr");
    recv(8'h5E, "R9 0xFF"); mack(1); recv(8'h3C, "R9 wrap to 0x00"); mack(1);
    recv(8'h00, "R9 0x01"); mack(0);
    @(negedge clk); ev_txreq = 1; @(negedge clk); ev_txreq = 0;
    chk(!tx_vld, "R10 no byte after NACK", tx_vld, 0);
    pulse_stop();

    pulse_start(); send(AW_W, 1, "R11 addr"); send(8'h20, 1, "R11 word");
    send(8'h99, 1, "R11 data");
    pulse_start(); send(AW_R, 1, "R11 read after restart");
    recv(8'h00, "R11 counter 0x21"); mack(0); pulse_stop();
    pulse_start(); send(AW_W, 1, "R11 no cycle started"); pulse_stop();
    settle();
    rand_read(8'h20, 8'h00, "R11 abandoned data not committed");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule